// File: doc/BRIEF.md
# Limit-Wrapping Interval Timer Array

This unit provides one interval timer for each CPU plus one shared master timer. Every timer has a counter and a programmable limit. When the counter is about to reach its limit, it reloads to 1 and sets a sticky limit-reached flag. Because the counter never holds the limit value itself, the flag fires once every limit minus one ticks. The flag drives an interrupt line. A per-CPU timer drives the priority-14 line of its own CPU only. The master timer drives the priority-10 line of every CPU at once.

Software reaches the timers over a simple word-addressed bus. Writes take effect at the clock edge. Read data is combinational and valid in the same cycle as the address. Limit and count words use one layout: the flag in the top bit, the 21-bit value in bits 30..10, and zeros below.

Software can acknowledge a flag in two ways. Reading the limit register acknowledges it. Writing a new limit acknowledges it and restarts the period. A separate no-clear alias changes the limit without disturbing the count or the flag. All counters advance only on cycles where the shared tick enable is high.

Top module: `itimer_array`

## Requirements
- R1: After reset, each per-CPU limit reads 0x009C4000 and each per-CPU control reads 1. Every count reads 0x00000400 (value 1). The master limit and master config read 0, and all interrupt lines are low.
- R2: Limit and count words read as {flag in bit 31, value in bits 30..10, zero in bits 9..0}. On a write, only bits 30..10 are used.
- R3: A running counter increases by exactly one on each clock edge where tick_en is high. It holds its value when tick_en is low.
- R4: On a tick where count+1 equals a limit of at least 2, the count reloads to 1 and the flag sets, giving a period of limit-1 ticks. A limit below 2 never sets the flag. In that case the counter wraps from all ones back to 1.
- R5: The flag of per-CPU timer i drives irq_l14[i] and no other line.
- R6: The master flag drives every bit of irq_l10.
- R7: Reading a limit register returns the flag and the limit, and clears the flag at that edge. A wrap in the same cycle wins, so the flag stays set.
- R8: Writing a limit register loads the limit, sets the count to 1 and clears the flag.
- R9: Writing the no-clear alias loads the limit only. The count and the flag are left as they are.
- R10: Bit 0 of a per-CPU control register enables counting (1 = run). Bit 0 of the master config register freezes the master counter (1 = hold).
- R11: Per-CPU bank i starts at word i*BANK_STRIDE, with offsets limit 0, count 1, no-clear 2, control 3. The master bank starts at N_CPU*BANK_STRIDE, with offsets limit 0, count 1, no-clear 2, reserved 3 and config 4. The count registers, the reserved word and unmapped words ignore writes. The reserved word, the no-clear words and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable shared by all timers |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_l14 | output | N_CPU | Per-CPU priority-14 interrupt, one bit per CPU |
| irq_l10 | output | N_CPU | Master priority-10 interrupt, replicated to every CPU |

## Verification
On every cycle, the assertions check four things:
- A rising interrupt line always follows a tick.
- A limit write, or a limit read on a cycle without a tick, leaves the line low on the next cycle.
- A no-clear write on a cycle without a tick leaves the line unchanged.
- Limit and count reads keep bits 9..0 at zero.

Some behaviours can only be shown by the directed scenarios, because they depend on exact counts:
- the period of limit-1 ticks
- the reset values
- the read-versus-wrap race
- the freeze and run controls
- the address map with its write-ignored words

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int DATA_W    = 32;
  localparam int VAL_W     = 21;
  localparam int VAL_LSB   = 10;
  localparam int FLAG_BIT  = 31;
  localparam int CPU_REGS  = 4;
  localparam int MST_REGS  = 5;

  localparam logic [2:0] OFS_LIM = 3'd0;
  localparam logic [2:0] OFS_CNT = 3'd1;
  localparam logic [2:0] OFS_LNC = 3'd2;
  localparam logic [2:0] OFS_CTL = 3'd3;
  localparam logic [2:0] OFS_RSV = 3'd3;
  localparam logic [2:0] OFS_CFG = 3'd4;

  localparam logic [DATA_W-1:0] CPU_LIM_RST_WORD = 32'h009C_4000;
  localparam logic [VAL_W-1:0]  CPU_LIM_RST      = CPU_LIM_RST_WORD[FLAG_BIT-1:VAL_LSB];

  function automatic logic [DATA_W-1:0] pack_word(input logic flag, input logic [VAL_W-1:0] v);
    return {flag, v, {VAL_LSB{1'b0}}};
  endfunction

  function automatic logic [VAL_W-1:0] unpack_val(input logic [DATA_W-1:0] w);
    return w[FLAG_BIT-1:VAL_LSB];
  endfunction
endpackage

// File: rtl/itimer_rst_sync.sv
module itimer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/itimer_decode.sv
module itimer_decode #(
  parameter int N_CPU       = 4,
  parameter int BANK_STRIDE = 4,
  parameter int AW          = 6
) (
  input  logic             en,
  input  logic [AW-1:0]    addr,
  output logic [N_CPU-1:0] cpu_hit,
  output logic             mst_hit,
  output logic [2:0]       ofs
);
  import itimer_pkg::*;

  localparam int SW    = $clog2(BANK_STRIDE);
  localparam int BW    = AW - SW;
  localparam int MBASE = N_CPU * BANK_STRIDE;

  logic [BW-1:0] bank;
  logic [SW-1:0] low;
  logic [AW-1:0] mofs;
  logic          low_ok;

  assign bank   = addr[AW-1:SW];
  assign low    = addr[SW-1:0];
  assign mofs   = addr - AW'(MBASE);
  assign low_ok = 32'(low) < 32'(CPU_REGS);

  for (genvar i = 0; i < N_CPU; i++) begin : g_hit
    assign cpu_hit[i] = en && low_ok && (bank == BW'(i));
  end

  assign mst_hit = en && (addr >= AW'(MBASE)) && (32'(mofs) < 32'(MST_REGS));

  always_comb begin
    if (mst_hit) ofs = mofs[2:0];
    else         ofs = 3'(low);
  end
endmodule

// File: rtl/itimer_core.sv
module itimer_core #(
  parameter int              CW      = 21,
  parameter logic [CW-1:0]   LIM_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          lim_ld_i,
  input  logic          lim_nc_i,
  input  logic          flag_clr_i,
  input  logic [CW-1:0] lim_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lim_o,
  output logic          flag_o
);
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] MIN_LIM = CW'(2);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] lim_q, lim_nxt;
  logic          flag_q, flag_nxt;
  logic [CW:0]   inc;
  logic          wrap;

  assign inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};

  always_comb begin
    cnt_nxt  = cnt_q;
    lim_nxt  = lim_q;
    flag_nxt = flag_q;
    wrap     = 1'b0;
    if (tick_i) begin
      if ((lim_q >= MIN_LIM) && (inc == {1'b0, lim_q})) begin
        cnt_nxt = ONE;
        wrap    = 1'b1;
      end else if (&cnt_q) begin
        cnt_nxt = ONE;
      end else begin
        cnt_nxt = inc[CW-1:0];
      end
    end
    if (flag_clr_i) flag_nxt = 1'b0;
    if (wrap)       flag_nxt = 1'b1;
    if (lim_nc_i)   lim_nxt  = lim_val_i;
    if (lim_ld_i) begin
      lim_nxt  = lim_val_i;
      cnt_nxt  = ONE;
      flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ONE;
      lim_q  <= LIM_RST;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      lim_q  <= lim_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/itimer_array.sv
module itimer_array #(
  parameter int N_CPU       = 4,
  parameter int BANK_STRIDE = 4,
  parameter int AW          = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [N_CPU-1:0] irq_l14,
  output logic [N_CPU-1:0] irq_l10
);
  import itimer_pkg::*;

  logic             srst_n;
  logic [N_CPU-1:0] cpu_hit;
  logic             mst_hit;
  logic [2:0]       ofs;
  logic [VAL_W-1:0] wval;

  logic [VAL_W-1:0] cpu_cnt  [N_CPU];
  logic [VAL_W-1:0] cpu_lim  [N_CPU];
  logic [N_CPU-1:0] cpu_flag;
  logic [N_CPU-1:0] run_q, run_nxt;

  logic [VAL_W-1:0] mst_cnt, mst_lim;
  logic             mst_flag;
  logic             frz_q, frz_nxt;
  logic             mst_lim_ld, mst_lim_nc, mst_rd_clr, mst_cfg_wr;

  itimer_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  itimer_decode #(
    .N_CPU       (N_CPU),
    .BANK_STRIDE (BANK_STRIDE),
    .AW          (AW)
  ) u_dec (
    .en      (bus_en),
    .addr    (bus_addr),
    .cpu_hit (cpu_hit),
    .mst_hit (mst_hit),
    .ofs     (ofs)
  );

  assign wval = unpack_val(bus_wdata);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic lim_ld, lim_nc, rd_clr, ctl_wr;

    assign lim_ld = cpu_hit[i] &&  bus_wr && (ofs == OFS_LIM);
    assign lim_nc = cpu_hit[i] &&  bus_wr && (ofs == OFS_LNC);
    assign rd_clr = cpu_hit[i] && !bus_wr && (ofs == OFS_LIM);
    assign ctl_wr = cpu_hit[i] &&  bus_wr && (ofs == OFS_CTL);

    always_comb begin
      run_nxt[i] = run_q[i];
      if (ctl_wr) run_nxt[i] = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) run_q[i] <= 1'b1;
      else         run_q[i] <= run_nxt[i];
    end

    itimer_core #(
      .CW      (VAL_W),
      .LIM_RST (CPU_LIM_RST)
    ) u_tmr (
      .clk        (clk),
      .rst_n      (srst_n),
      .tick_i     (tick_en && run_q[i]),
      .lim_ld_i   (lim_ld),
      .lim_nc_i   (lim_nc),
      .flag_clr_i (rd_clr),
      .lim_val_i  (wval),
      .cnt_o      (cpu_cnt[i]),
      .lim_o      (cpu_lim[i]),
      .flag_o     (cpu_flag[i])
    );
  end

  assign mst_lim_ld = mst_hit &&  bus_wr && (ofs == OFS_LIM);
  assign mst_lim_nc = mst_hit &&  bus_wr && (ofs == OFS_LNC);
  assign mst_rd_clr = mst_hit && !bus_wr && (ofs == OFS_LIM);
  assign mst_cfg_wr = mst_hit &&  bus_wr && (ofs == OFS_CFG);

  always_comb begin
    frz_nxt = frz_q;
    if (mst_cfg_wr) frz_nxt = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) frz_q <= 1'b0;
    else         frz_q <= frz_nxt;
  end

  itimer_core #(
    .CW      (VAL_W),
    .LIM_RST ('0)
  ) u_mst (
    .clk        (clk),
    .rst_n      (srst_n),
    .tick_i     (tick_en && !frz_q),
    .lim_ld_i   (mst_lim_ld),
    .lim_nc_i   (mst_lim_nc),
    .flag_clr_i (mst_rd_clr),
    .lim_val_i  (wval),
    .cnt_o      (mst_cnt),
    .lim_o      (mst_lim),
    .flag_o     (mst_flag)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (cpu_hit[i]) begin
        case (ofs)
          OFS_LIM: bus_rdata = pack_word(cpu_flag[i], cpu_lim[i]);
          OFS_CNT: bus_rdata = pack_word(cpu_flag[i], cpu_cnt[i]);
          OFS_CTL: bus_rdata = {31'b0, run_q[i]};
          default: bus_rdata = '0;
        endcase
      end
    end
    if (mst_hit) begin
      case (ofs)
        OFS_LIM: bus_rdata = pack_word(mst_flag, mst_lim);
        OFS_CNT: bus_rdata = pack_word(mst_flag, mst_cnt);
        OFS_CFG: bus_rdata = {31'b0, frz_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_l14 = cpu_flag;
  assign irq_l10 = {N_CPU{mst_flag}};
endmodule

// File: rtl/itimer_array_chk.sv
module itimer_array_chk #(
  parameter int N_CPU       = 4,
  parameter int BANK_STRIDE = 4,
  parameter int AW          = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             bus_en,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [N_CPU-1:0] irq_l14,
  input logic [N_CPU-1:0] irq_l10
);
  for (genvar i = 0; i < N_CPU; i++) begin : g_chk
    localparam logic [AW-1:0] A_LIM = AW'(i * BANK_STRIDE);
    localparam logic [AW-1:0] A_CNT = AW'(i * BANK_STRIDE + 1);
    localparam logic [AW-1:0] A_LNC = AW'(i * BANK_STRIDE + 2);

    // R4
    irq_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_l14[i]) |-> $past(tick_en));

    // R8
    lim_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_addr == A_LIM) |=> !irq_l14[i]);

    // R7
    lim_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && bus_addr == A_LIM && !tick_en) |=> !irq_l14[i]);

    // R9
    lnc_keep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_addr == A_LNC && !tick_en) |=> (irq_l14[i] == $past(irq_l14[i])));

    // R2
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_wr && (bus_addr == A_LIM || bus_addr == A_CNT)) |-> (bus_rdata[9:0] == 10'b0));
  end

  // R6
  mst_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_l10[0]) |-> $past(tick_en));
endmodule

bind itimer_array itimer_array_chk #(
  .N_CPU       (N_CPU),
  .BANK_STRIDE (BANK_STRIDE),
  .AW          (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_l14   (irq_l14),
  .irq_l10   (irq_l10)
);

// File: tb/test_itimer_array.sv
module test_itimer_array;
  localparam int N   = 4;
  localparam int STR = 4;
  localparam int AW  = 6;
  localparam int MB  = N * STR;

  logic          clk;
  logic          rst_n;
  logic          tick_en;
  logic          bus_en;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_l14;
  logic [N-1:0]  irq_l10;

  int n_chk  = 0;
  int n_fail = 0;

  itimer_array #(.N_CPU(N), .BANK_STRIDE(STR), .AW(AW)) i_itimer_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_l14   (irq_l14),
    .irq_l10   (irq_l10)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] w(input logic flag, input int v);
    return {flag, 21'(v), 10'b0};
  endfunction

  function automatic logic [AW-1:0] ca(input int cpu, input int off);
    return AW'(cpu * STR + off);
  endfunction

  function automatic logic [AW-1:0] ma(input int off);
    return AW'(MB + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) step();
    tick_en = 1'b0;
  endtask

  task automatic bwrite(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    step();
    bus_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_l14", 32'(irq_l14), 32'h0);
    chk("R1 irq_l10", 32'(irq_l10), 32'h0);
    bread(ca(0, 0), d); chk("R1 cpu0 limit", d, 32'h009C_4000);
    bread(ca(3, 3), d); chk("R1 cpu3 control", d, 32'h1);
    bread(ca(1, 1), d); chk("R1 cpu1 count", d, 32'h0000_0400);
    bread(ma(4), d);    chk("R1 master config", d, 32'h0);
    bread(ma(0), d);    chk("R1 master limit", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    ticks(3);
    bread(ca(2, 1), d); chk("R3 count after 3 ticks", d, w(0, 4));
    repeat (2) step();
    bread(ca(2, 1), d); chk("R3 count holds without tick", d, w(0, 4));
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    bwrite(ca(0, 0), w(0, 5));
    ticks(3);
    chk("R4 no flag before limit-1 ticks", 32'(irq_l14[0]), 32'h0);
    bread(ca(0, 1), d); chk("R4 count before wrap", d, w(0, 4));
    ticks(1);
    chk("R5 only own line", 32'(irq_l14), 32'h1);
    chk("R5 master line untouched", 32'(irq_l10), 32'h0);
    bread(ca(0, 1), d); chk("R4 count reloads to 1", d, w(1, 1));
    bread(ca(0, 0), d); chk("R7 limit read shows flag", d, 32'h8000_1400);
    chk("R7 read clears flag", 32'(irq_l14[0]), 32'h0);
    ticks(3);
    chk("R4 second period not yet", 32'(irq_l14[0]), 32'h0);
    ticks(1);
    chk("R4 second period fires", 32'(irq_l14[0]), 32'h1);
    bread(ca(0, 0), d);
  endtask

  task automatic t_race();
    logic [31:0] d;
    bwrite(ca(1, 0), w(0, 3));
    ticks(1);
    tick_en = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = ca(1, 0);
    #1 d = bus_rdata;
    step();
    bus_en = 1'b0; tick_en = 1'b0;
    chk("R7 race read data", d, w(0, 3));
    chk("R7 wrap wins over read clear", 32'(irq_l14[1]), 32'h1);
    bread(ca(1, 0), d); chk("R7 flag seen on later read", d, w(1, 3));
    chk("R7 later read clears", 32'(irq_l14[1]), 32'h0);
  endtask

  task automatic t_no_clear();
    logic [31:0] d;
    bwrite(ca(2, 0), w(0, 6));
    ticks(5);
    chk("R4 cpu2 period 5", 32'(irq_l14[2]), 32'h1);
    bwrite(ca(2, 2), w(0, 9));
    chk("R9 flag kept", 32'(irq_l14[2]), 32'h1);
    bread(ca(2, 1), d); chk("R9 count kept", d, w(1, 1));
    ticks(7);
    bread(ca(2, 1), d); chk("R9 new limit used", d, w(1, 8));
    bread(ca(2, 0), d); chk("R9 limit loaded", d, w(1, 9));
    bread(ca(2, 2), d); chk("R11 no-clear alias reads 0", d, 32'h0);
  endtask

  task automatic t_lim_write();
    logic [31:0] d;
    bwrite(ca(3, 0), w(0, 3));
    ticks(3);
    chk("R8 precondition flag", 32'(irq_l14[3]), 32'h1);
    bwrite(ca(3, 0), w(0, 4));
    chk("R8 write clears flag", 32'(irq_l14[3]), 32'h0);
    bread(ca(3, 1), d); chk("R8 count set to 1", d, w(0, 1));
  endtask

  task automatic t_master();
    logic [31:0] d;
    bwrite(ma(0), w(0, 3));
    ticks(1);
    chk("R6 master not yet", 32'(irq_l10), 32'h0);
    ticks(1);
    chk("R6 master to all CPUs", 32'(irq_l10), 32'hF);
    bread(ma(1), d); chk("R6 master count reload", d, w(1, 1));
    bread(ma(0), d); chk("R7 master limit read", d, w(1, 3));
    chk("R7 master read clears", 32'(irq_l10), 32'h0);
    ticks(1);
    bwrite(ma(4), 32'h1);
    ticks(3);
    bread(ma(1), d); chk("R10 master frozen", d, w(0, 2));
    bread(ma(4), d); chk("R10 config readback", d, 32'h1);
    bwrite(ma(4), 32'h0);
    ticks(1);
    chk("R10 master resumes and wraps", 32'(irq_l10), 32'hF);
    bread(ma(0), d);
  endtask

  task automatic t_run();
    logic [31:0] d;
    bwrite(ca(1, 0), w(0, 3));
    bwrite(ca(1, 3), 32'h0);
    ticks(3);
    bread(ca(1, 1), d); chk("R10 stopped cpu holds", d, w(0, 1));
    chk("R10 stopped cpu no irq", 32'(irq_l14[1]), 32'h0);
    bread(ca(1, 3), d); chk("R10 control readback", d, 32'h0);
    bwrite(ca(1, 3), 32'h1);
    ticks(1);
    bread(ca(1, 1), d); chk("R10 restarted cpu counts", d, w(0, 2));
  endtask

  task automatic t_map();
    logic [31:0] d;
    bwrite(ma(3), 32'hFFFF_FFFF);
    bread(ma(3), d); chk("R11 reserved reads 0", d, 32'h0);
    bwrite(ca(3, 0), w(0, 50));
    bwrite(ca(3, 1), w(0, 100));
    bread(ca(3, 1), d); chk("R11 count write ignored", d, w(0, 1));
    bwrite(ca(3, 2), 32'hFFFF_FFFF);
    bread(ca(3, 0), d); chk("R2 only value bits stored", d, 32'h7FFF_FC00);
    bread(ma(5), d); chk("R11 unmapped reads 0", d, 32'h0);
  endtask

  task automatic t_small();
    logic [31:0] d;
    bwrite(ca(2, 0), w(0, 1));
    ticks(5);
    chk("R4 limit below 2 never flags", 32'(irq_l14[2]), 32'h0);
    bread(ca(2, 1), d); chk("R4 limit below 2 keeps counting", d, w(0, 6));
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_count();
    t_wrap();
    t_race();
    t_no_clear();
    t_lim_write();
    t_master();
    t_run();
    t_map();
    t_small();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule